// File: doc/BRIEF.md
# Timed event record stream decoder

The block reads a packed list of timed event records from word-addressed memory over a Wishbone read master and presents every record as one parallel event on a valid/ready output. Software starts a pass with a one-cycle pulse on `start_i`. The block then reads words from address zero upward and splits each word into bytes, taking the lowest byte first. It rebuilds records of variable length even when a record spans several words. It stops when it finds a record whose length byte is zero. The `busy_o` output stands in for the readable enable bit. It is high for the whole pass and drops by itself at the end, so software can poll it to see that the pass is complete.

A record begins with a length byte that counts every byte of the record, the length byte included. Four fields follow, each stored with its least significant byte first: a 3-byte channel, an 8-byte timestamp, a 2-byte address, and then a payload of length minus 14 bytes, which may be 1 to 64 bytes. The design has three controllers.

- The run controller (`evw_ctrl`) has two states. It moves from C_IDLE to C_RUN on a start pulse, and from C_RUN back to C_IDLE when the end of the list is found.
- The word fetcher (`evw_fetch`) has three states. It moves from F_IDLE to F_REQ on the go pulse. It moves from F_REQ to F_HOLD on a bus acknowledge. In F_HOLD it goes back to F_REQ after the last byte of the word is taken, and to F_IDLE when it is told to halt.
- The record parser (`evw_parse`) has four states. It moves from P_IDLE to P_LEN on the go pulse. From P_LEN it moves to P_IDLE on a zero length byte, to P_EMIT on a length of 1, and to P_BODY on any other length. It moves from P_BODY to P_EMIT when the last byte of the record is taken, and from P_EMIT to P_LEN when the event is accepted.

Top module: `evrec_walker`

## Requirements
- R1: After reset, `busy_o`, `ev_valid_o`, `wb_cyc_o` and `wb_stb_o` are all low.
- R2: A start pulse sets `busy_o`. The first read goes to word address 0, and each later read goes to the previous address plus one.
- R3: Byte k of the stream is taken from word k / W at bits 8*(k mod W) and up, where W is the word width in bytes.
- R4: Each record is decoded as follows. The length byte L counts the whole record. Bytes 1..3 form the channel, bytes 4..11 form the timestamp and bytes 12..13 form the address, all with the least significant byte first. Bytes 14..L-1 are payload bytes 0..L-15. Each record appears on the output exactly once and in stream order.
- R5: A record that spans one or more word boundaries is decoded exactly as if it sat inside a single word.
- R6: `ev_len_o` equals L-14. `ev_data_o` holds payload byte i at bits 8i and up, and every bit above the payload is zero.
- R7: A zero length byte ends the pass. `busy_o` falls, no event is produced for it, and no further bus cycle starts. The number of word reads is (index of the terminator byte) / W + 1.
- R8: While `ev_valid_o` is high and `ev_ready_i` is low, every event output holds its value, and no byte of the stream is consumed.
- R9: `wb_stb_o` is high only while `wb_cyc_o` is high, and both `wb_stb_o` and `wb_adr_o` hold their values until `wb_ack_i` is seen.
- R10: A start pulse after a pass has ended begins a new pass from word 0.
- R11: A start pulse while `busy_o` is high has no effect. The read addresses and the event sequence carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse (writing 1 to the enable bit) |
| busy_o | output | 1 | Enable readback, high while a pass runs |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_adr_o | output | ADDR_W | Word address |
| wb_dat_i | input | 8*WORD_BYTES | Read data |
| wb_ack_i | input | 1 | Bus acknowledge |
| ev_valid_o | output | 1 | Event valid |
| ev_ready_i | input | 1 | Event accepted by the consumer |
| ev_chan_o | output | 24 | Event channel |
| ev_stamp_o | output | 64 | Event timestamp |
| ev_addr_o | output | 16 | Event address |
| ev_data_o | output | 8*DATA_BYTES | Payload, zero-extended |
| ev_len_o | output | $clog2(DATA_BYTES+1) | Payload byte count |

## Verification
If the byte index inside the held word goes wrong, the fields of the next record come out misaligned, and this shows up at the first event after the error. If the parser miscounts bytes, the record boundary moves. Every later record is then shifted, and the number of reads at the end of the pass no longer matches. A stall that leaks bytes is caught by the scoreboard when the following event is compared. A fetcher that fails to halt shows extra bus cycles as soon as `busy_o` falls.

// File: rtl/evw_pkg.sv
package evw_pkg;
    typedef enum logic [1:0] {F_IDLE, F_REQ, F_HOLD} fetch_st_t;
    typedef enum logic [1:0] {P_IDLE, P_LEN, P_BODY, P_EMIT} parse_st_t;
    typedef enum logic {C_IDLE, C_RUN} ctrl_st_t;

    localparam int CHAN_BYTES  = 3;
    localparam int STAMP_BYTES = 8;
    localparam int ADDR_BYTES  = 2;
    localparam int CHAN_FIRST  = 1;
    localparam int STAMP_FIRST = CHAN_FIRST + CHAN_BYTES;
    localparam int ADDR_FIRST  = STAMP_FIRST + STAMP_BYTES;
    localparam int HDR_BYTES   = ADDR_FIRST + ADDR_BYTES;
endpackage

// File: rtl/evw_ctrl.sv
module evw_ctrl
    import evw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic done_i,
    output logic go_o,
    output logic busy_o
);
    ctrl_st_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= C_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            C_IDLE: if (start_i) st_d = C_RUN;
            C_RUN:  if (done_i)  st_d = C_IDLE;
            default: st_d = C_IDLE;
        endcase
    end

    always_comb begin
        go_o   = (st_q == C_IDLE) && start_i;
        busy_o = (st_q == C_RUN);
    end
endmodule

// File: rtl/evw_fetch.sv
module evw_fetch
    import evw_pkg::*;
#(
    parameter int WORD_BYTES = 64,
    parameter int ADDR_W     = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    go_i,
    input  logic                    halt_i,
    output logic                    cyc_o,
    output logic                    stb_o,
    output logic [ADDR_W-1:0]       adr_o,
    input  logic [WORD_BYTES*8-1:0] dat_i,
    input  logic                    ack_i,
    output logic                    byte_vld_o,
    output logic [7:0]              byte_o,
    input  logic                    take_i
);
    localparam int WORD_W = WORD_BYTES * 8;
    localparam int IDX_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);

    fetch_st_t          st_q, st_d;
    logic [WORD_W-1:0]  word_q;
    logic [IDX_W-1:0]   idx_q;
    logic [ADDR_W-1:0]  adr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= F_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            F_IDLE: if (go_i) st_d = F_REQ;
            F_REQ:  if (ack_i) st_d = F_HOLD;
            F_HOLD: begin
                if (halt_i)                          st_d = F_IDLE;
                else if (take_i && idx_q == LAST_IDX) st_d = F_REQ;
            end
            default: st_d = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            idx_q  <= '0;
            adr_q  <= '0;
        end else begin
            unique case (st_q)
                F_IDLE: if (go_i) adr_q <= '0;
                F_REQ: if (ack_i) begin
                    word_q <= dat_i;
                    idx_q  <= '0;
                end
                F_HOLD: if (!halt_i && take_i) begin
                    if (idx_q == LAST_IDX) adr_q <= adr_q + 1'b1;
                    else                   idx_q <= idx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        cyc_o      = (st_q == F_REQ);
        stb_o      = (st_q == F_REQ);
        adr_o      = adr_q;
        byte_vld_o = (st_q == F_HOLD);
        byte_o     = word_q[int'(idx_q)*8 +: 8];
    end
endmodule

// File: rtl/evw_parse.sv
module evw_parse
    import evw_pkg::*;
#(
    parameter int DATA_BYTES = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   go_i,
    input  logic                   byte_vld_i,
    input  logic [7:0]             byte_i,
    output logic                   take_o,
    output logic                   done_o,
    output logic                   valid_o,
    input  logic                   ready_i,
    output logic [23:0]            chan_o,
    output logic [63:0]            stamp_o,
    output logic [15:0]            addr_o,
    output logic [DATA_BYTES*8-1:0] data_o,
    output logic [$clog2(DATA_BYTES+1)-1:0] len_o
);
    localparam int DATA_W = DATA_BYTES * 8;
    localparam int DLEN_W = $clog2(DATA_BYTES + 1);
    localparam logic [7:0] HDR8  = 8'(HDR_BYTES);
    localparam logic [7:0] DMAX8 = 8'(DATA_BYTES);

    parse_st_t         st_q, st_d;
    logic [7:0]        len_q, cnt_q, didx;
    logic [23:0]       chan_q;
    logic [63:0]       stamp_q;
    logic [15:0]       addr_q;
    logic [DATA_W-1:0] data_q;
    logic              in_body;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= P_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            P_IDLE: if (go_i) st_d = P_LEN;
            P_LEN: if (byte_vld_i) begin
                if (byte_i == 8'd0)      st_d = P_IDLE;
                else if (byte_i == 8'd1) st_d = P_EMIT;
                else                     st_d = P_BODY;
            end
            P_BODY: if (byte_vld_i && (cnt_q + 8'd1 == len_q)) st_d = P_EMIT;
            P_EMIT: if (ready_i) st_d = P_LEN;
            default: st_d = P_IDLE;
        endcase
    end

    assign in_body = (st_q == P_BODY) && byte_vld_i;
    assign didx    = cnt_q - HDR8;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q   <= '0;
            cnt_q   <= '0;
            chan_q  <= '0;
            stamp_q <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else if ((st_q == P_LEN) && byte_vld_i && byte_i != 8'd0) begin
            len_q   <= byte_i;
            cnt_q   <= 8'd1;
            chan_q  <= '0;
            stamp_q <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else if (in_body) begin
            cnt_q <= cnt_q + 8'd1;
            if (int'(cnt_q) < STAMP_FIRST)
                chan_q[(int'(cnt_q) - CHAN_FIRST)*8 +: 8] <= byte_i;
            else if (int'(cnt_q) < ADDR_FIRST)
                stamp_q[(int'(cnt_q) - STAMP_FIRST)*8 +: 8] <= byte_i;
            else if (int'(cnt_q) < HDR_BYTES)
                addr_q[(int'(cnt_q) - ADDR_FIRST)*8 +: 8] <= byte_i;
            else if (didx < DMAX8)
                data_q[int'(didx)*8 +: 8] <= byte_i;
        end
    end

    always_comb begin
        take_o  = byte_vld_i && (st_q == P_LEN || st_q == P_BODY);
        done_o  = (st_q == P_LEN) && byte_vld_i && (byte_i == 8'd0);
        valid_o = (st_q == P_EMIT);
        chan_o  = chan_q;
        stamp_o = stamp_q;
        addr_o  = addr_q;
        data_o  = data_q;
        len_o   = (len_q > HDR8) ? DLEN_W'(len_q - HDR8) : '0;
    end
endmodule

// File: rtl/evrec_walker.sv
module evrec_walker
    import evw_pkg::*;
#(
    parameter int WORD_BYTES = 64,
    parameter int ADDR_W     = 16,
    parameter int DATA_BYTES = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start_i,
    output logic                             busy_o,
    output logic                             wb_cyc_o,
    output logic                             wb_stb_o,
    output logic [ADDR_W-1:0]                wb_adr_o,
    input  logic [WORD_BYTES*8-1:0]          wb_dat_i,
    input  logic                             wb_ack_i,
    output logic                             ev_valid_o,
    input  logic                             ev_ready_i,
    output logic [23:0]                      ev_chan_o,
    output logic [63:0]                      ev_stamp_o,
    output logic [15:0]                      ev_addr_o,
    output logic [DATA_BYTES*8-1:0]          ev_data_o,
    output logic [$clog2(DATA_BYTES+1)-1:0]  ev_len_o
);
    logic       go, done, bvld, take;
    logic [7:0] bval;

    evw_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_i(done),
        .go_o(go), .busy_o(busy_o)
    );

    evw_fetch #(.WORD_BYTES(WORD_BYTES), .ADDR_W(ADDR_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .go_i(go), .halt_i(done),
        .cyc_o(wb_cyc_o), .stb_o(wb_stb_o), .adr_o(wb_adr_o),
        .dat_i(wb_dat_i), .ack_i(wb_ack_i),
        .byte_vld_o(bvld), .byte_o(bval), .take_i(take)
    );

    evw_parse #(.DATA_BYTES(DATA_BYTES)) u_parse (
        .clk(clk), .rst_n(rst_n), .go_i(go),
        .byte_vld_i(bvld), .byte_i(bval), .take_o(take), .done_o(done),
        .valid_o(ev_valid_o), .ready_i(ev_ready_i),
        .chan_o(ev_chan_o), .stamp_o(ev_stamp_o), .addr_o(ev_addr_o),
        .data_o(ev_data_o), .len_o(ev_len_o)
    );
endmodule

// File: rtl/evrec_walker_chk.sv
module evrec_walker_chk #(
    parameter int ADDR_W     = 16,
    parameter int DATA_BYTES = 64
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            busy_o,
    input logic                            wb_cyc_o,
    input logic                            wb_stb_o,
    input logic [ADDR_W-1:0]               wb_adr_o,
    input logic                            wb_ack_i,
    input logic                            ev_valid_o,
    input logic                            ev_ready_i,
    input logic [23:0]                     ev_chan_o,
    input logic [63:0]                     ev_stamp_o,
    input logic [15:0]                     ev_addr_o,
    input logic [DATA_BYTES*8-1:0]         ev_data_o,
    input logic [$clog2(DATA_BYTES+1)-1:0] ev_len_o
);
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid_o && !ev_ready_i |=> ev_valid_o && $stable(ev_chan_o) &&
        $stable(ev_stamp_o) && $stable(ev_addr_o) && $stable(ev_data_o) && $stable(ev_len_o));

    p_stb_in_cyc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb_o |-> wb_cyc_o);

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb_o && !wb_ack_i |=> wb_stb_o && $stable(wb_adr_o));

    p_quiet_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !wb_cyc_o && !ev_valid_o);

    p_end_no_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !ev_valid_o && !wb_cyc_o);

    p_zero_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid_o |-> (ev_data_o >> (int'(ev_len_o) * 8)) == '0);
endmodule

bind evrec_walker evrec_walker_chk #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy_o(busy_o),
    .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_adr_o(wb_adr_o), .wb_ack_i(wb_ack_i),
    .ev_valid_o(ev_valid_o), .ev_ready_i(ev_ready_i),
    .ev_chan_o(ev_chan_o), .ev_stamp_o(ev_stamp_o), .ev_addr_o(ev_addr_o),
    .ev_data_o(ev_data_o), .ev_len_o(ev_len_o)
);

// File: tb/evrec_walker_test.sv
module evrec_walker_test;
    localparam int WB = 8;
    localparam int AW = 16;
    localparam int DB = 64;
    localparam int LW = $clog2(DB + 1);

    typedef struct {
        logic [23:0]   ch;
        logic [63:0]   ts;
        logic [15:0]   ad;
        logic [DB*8-1:0] dt;
        int            n;
    } ev_t;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ack = 1'b0, ready = 1'b0;
    logic [WB*8-1:0] dat = '0;
    logic busy, cyc, stb, valid;
    logic [AW-1:0] adr;
    logic [23:0] ch;
    logic [63:0] ts;
    logic [15:0] ad;
    logic [DB*8-1:0] dt;
    logic [LW-1:0] dl;

    int errors = 0, checks = 0;
    logic [7:0] mem [0:1023];
    ev_t exp_q[$];
    int wp = 0, reads = 0, exp_adr = 0;
    bit rdy_rand = 1'b1;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    evrec_walker #(.WORD_BYTES(WB), .ADDR_W(AW), .DATA_BYTES(DB)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy),
        .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_adr_o(adr), .wb_dat_i(dat), .wb_ack_i(ack),
        .ev_valid_o(valid), .ev_ready_i(ready), .ev_chan_o(ch), .ev_stamp_o(ts),
        .ev_addr_o(ad), .ev_data_o(dt), .ev_len_o(dl)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_n(input logic [63:0] v, input int nb);
        for (int k = 0; k < nb; k++) begin
            mem[wp] = v[k*8 +: 8];
            wp++;
        end
    endtask

    // Driver: writes one record into memory (R3/R4 layout) and queues its event.
    task automatic add_rec(input logic [23:0] c, input logic [63:0] t, input logic [15:0] a,
                           input int n, input int seed);
        ev_t e;
        e.ch = c; e.ts = t; e.ad = a; e.n = n; e.dt = '0;
        put_n(64'(n + 14), 1);
        put_n(64'(c), 3);
        put_n(t, 8);
        put_n(64'(a), 2);
        for (int k = 0; k < n; k++) begin
            e.dt[k*8 +: 8] = 8'((seed + k * 37) & 8'hFF);
            mem[wp] = e.dt[k*8 +: 8];
            wp++;
        end
        exp_q.push_back(e);
    endtask

    task automatic clear_mem();
        for (int k = 0; k < 1024; k++) mem[k] = 8'hA5;
        wp = 0;
        exp_q.delete();
    endtask

    // Memory model: one wait-free acknowledge per request; R2 address order checked here.
    always @(negedge clk) begin
        if (cyc && stb && !ack) begin
            check(int'(adr) == exp_adr, "R2 read address", 64'(adr), 64'(exp_adr));
            for (int k = 0; k < WB; k++) dat[k*8 +: 8] = mem[(int'(adr) * WB + k) % 1024];
            ack = 1'b1;
            exp_adr++;
            reads++;
        end else begin
            ack = 1'b0;
        end
    end

    // Monitor / scoreboard
    bit stall_pend = 1'b0;
    logic [23:0] s_ch; logic [63:0] s_ts; logic [15:0] s_ad; logic [DB*8-1:0] s_dt; logic [LW-1:0] s_dl;
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_pend)
                check(valid && ch == s_ch && ts == s_ts && ad == s_ad && dt == s_dt && dl == s_dl,
                      "R8 stalled event held", 64'(valid), 64'd1);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ready = rdy_rand ? lfsr[0] : 1'b1;
            if (valid && ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected extra event", 64'(ch), 64'd0);
                end else begin
                    ev_t e;
                    e = exp_q.pop_front();
                    check(ch == e.ch, "R4 channel", 64'(ch), 64'(e.ch));
                    check(ts == e.ts, "R4 timestamp", ts, e.ts);
                    check(ad == e.ad, "R4 address", 64'(ad), 64'(e.ad));
                    check(int'(dl) == e.n, "R6 payload length", 64'(dl), 64'(e.n));
                    check(dt == e.dt, "R5 R6 payload bytes", dt[63:0], e.dt[63:0]);
                end
            end
            stall_pend = valid && !ready;
            s_ch = ch; s_ts = ts; s_ad = ad; s_dt = dt; s_dl = dl;
        end
    end

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_pass(input int term_idx, input bit poke_mid, input string tag);
        reads = 0;
        exp_adr = 0;
        pulse_start();
        check(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
        if (poke_mid) begin
            repeat (40) @(negedge clk);
            pulse_start(); // R11: ignored while busy
        end
        while (busy) @(negedge clk);
        check(exp_q.size() == 0, {tag, " R4 all events seen"}, 64'(exp_q.size()), 64'd0);
        check(reads == term_idx / WB + 1, {tag, " R7 read count"}, 64'(reads), 64'(term_idx / WB + 1));
        check(!valid && !cyc, {tag, " R7 quiet at end"}, {62'd0, valid, cyc}, 64'd0);
        repeat (20) @(negedge clk);
        check(!valid && !cyc && !busy && reads == term_idx / WB + 1, {tag, " R7 stays idle"},
              64'(reads), 64'(term_idx / WB + 1));
    endtask

    task automatic build_a();
        clear_mem();
        add_rec(24'h000001, 64'h23, 16'h0012, 1, 8'h33);
        add_rec(24'h000901, 64'h0902_0000_8877_6655, 16'h0911, 64, 8'h11);
        add_rec(24'h000081, 64'h0288, 16'h0088, 2, 8'h88);
        put_n(64'd0, 1);
    endtask

    task automatic build_b();
        clear_mem();
        add_rec(24'hABCDEF, 64'hFEDC_BA98_7654_3210, 16'hBEEF, 2, 8'h5A);
        add_rec(24'h123456, 64'h0102_0304_0506_0708, 16'h00FF, 10, 8'hC3);
        put_n(64'd0, 1); // terminator lands on byte 0 of word 5
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !valid && !cyc && !stb, "R1 reset state",
              {60'd0, busy, valid, cyc, stb}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        build_a();
        run_pass(wp - 1, 1'b1, "R3 R5 R11 stream A");
        build_b();
        run_pass(wp - 1, 1'b0, "R5 stream B");
        build_b();
        rdy_rand = 1'b0;
        run_pass(wp - 1, 1'b0, "R10 restart");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule